// File: doc/BRIEF.md
# Pin Link Detection Sequencer

This block scans a set of tester pins to find groups of pins that are wired together on the board under test. It owns a drive enable and a drive value for every pin and reads back the logic level seen on every pin. For each pin in ascending index order it drives that pin low and then high, and notes which higher-indexed pins follow. Every such candidate is then driven low and high in turn while the source pin is watched. A link is kept only if the change also passes in this reverse direction.

Confirmed groups get labels 1, 2, 3 and so on, in the order they are found. Label 0 means that a pin has no link. Pins flagged in the exclusion mask are never driven and stay at label 0. Such pins are, for example, pins shorted to a supply rail or pins that cannot be driven. A pin that already carries a label is not used again as a source. Each drive step holds for a programmable number of settle cycles before the readback is sampled. When the scan ends, every drive enable is released before done is raised. The labels stay on the output until the next start.

Top module: `link_scan_seq`

## Requirements
- R1: After reset, done_o is 0, drv_en_o is all zero and every label is 0.
- R2: A start_i pulse while idle or done clears all labels and begins a scan. A start_i while a scan runs has no effect on the result. Labels hold their values after done until the next start.
- R3: At most one bit of drv_en_o is set in any cycle, and no bit of a pin excluded at start is ever set.
- R4: In the forward step the source is driven low (drv_val_o bit 0) and then high (bit 1). A higher-indexed, non-excluded, unlabeled pin becomes a candidate only if it reads 0 in the low step and 1 in the high step.
- R5: Each candidate is driven low and then high. It joins the source's group only if the source pin reads 0 and then 1. A pin that follows the source in one direction only keeps label 0.
- R6: A group may hold any number of pins. The source and all of its confirmed pins receive the same label.
- R7: Labels are numbered 1, 2, ... in the order of the group's lowest pin index. Label 0 means unlinked. Label of pin p is label_o[p*LBL_W +: LBL_W].
- R8: Excluded pins keep label 0 and are never used as source or as target.
- R9: A pin that is already labeled is not used as a new source, and its label is never rewritten during a scan.
- R10: Every drive step holds a constant drv_en_o/drv_val_o for exactly settle_i+1 cycles, where settle_i is the value taken at start.
- R11: After the last source, drv_en_o is all zero for one cycle before done_o rises. done_o stays at 1 with drv_en_o zero until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a scan (used only while idle or done) |
| settle_i | input | SETTLE_W | Settle cycles minus one for each drive step |
| excl_i | input | NUM_PINS | Pins that must not be driven or labeled |
| pin_i | input | NUM_PINS | Readback logic level of each pin |
| drv_en_o | output | NUM_PINS | Per-pin drive enable |
| drv_val_o | output | NUM_PINS | Per-pin drive value |
| done_o | output | 1 | Scan finished, labels valid |
| label_o | output | NUM_PINS*LBL_W | Flattened per-pin group label |

## Verification
Two things can fall in the same cycle: the label write that closes the group of the final source, and the move to the release step that ends the scan. Groups that include pin NUM_PINS-1 make the last write happen right at the end of the scan. The readback and the pin labels are then judged after done against a group model built in the bench from the wiring it simulates. A scan with a linked top pin is also checked for the released drive enables one cycle before done rises. One-way followers, excluded pins that read stuck high and a sweep of pseudo-random wirings with varying settle counts cover the forward and reverse decisions.

// File: rtl/link_scan_pkg.sv
package link_scan_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_SRC, ST_FLO, ST_FHI, ST_RSEL, ST_RLO, ST_RHI, ST_COMMIT, ST_REL, ST_DONE
  } scan_st_e;
endpackage

// File: rtl/link_settle_timer.sv
module link_settle_timer #(
  parameter int SETTLE_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                restart_i,
  input  logic [SETTLE_W-1:0] limit_i,
  output logic                expired_o
);
  logic [SETTLE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == limit_i);

  // R10: counter never runs past the settle limit
  assert_cnt_in_window_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= limit_i);
endmodule

// File: rtl/link_first_set.sv
module link_first_set #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  mask_i,
  output logic [IW-1:0] idx_o,
  output logic          valid_o
);
  always_comb begin
    idx_o   = '0;
    valid_o = 1'b0;
    for (int i = N-1; i >= 0; i--) begin
      if (mask_i[i]) begin
        idx_o   = IW'(i);
        valid_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/link_label_store.sv
module link_label_store #(
  parameter int N  = 8,
  parameter int LW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [N-1:0]  wr_mask_i,
  input  logic [LW-1:0] wr_lbl_i,
  output logic [N*LW-1:0] labels_o,
  output logic [N-1:0]  unlab_o
);
  for (genvar p = 0; p < N; p++) begin : g_pin
    logic [LW-1:0] lbl_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           lbl_q <= '0;
      else if (clr_i)        lbl_q <= '0;
      else if (wr_mask_i[p]) lbl_q <= wr_lbl_i;
    end
    assign labels_o[p*LW +: LW] = lbl_q;
    assign unlab_o[p]           = (lbl_q == '0);
  end

  // R9: a labeled pin is never rewritten
  assert_no_relabel_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_mask_i & ~unlab_o) == '0);
  // R7: written labels are never the unlinked code
  assert_nonzero_label_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_mask_i != '0) |-> (wr_lbl_i != '0));
endmodule

// File: rtl/link_scan_seq.sv
module link_scan_seq
  import link_scan_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int SETTLE_W = 4,
  localparam int IW      = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
  localparam int LBL_W   = $clog2(NUM_PINS/2 + 2)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [SETTLE_W-1:0]       settle_i,
  input  logic [NUM_PINS-1:0]       excl_i,
  input  logic [NUM_PINS-1:0]       pin_i,
  output logic [NUM_PINS-1:0]       drv_en_o,
  output logic [NUM_PINS-1:0]       drv_val_o,
  output logic                      done_o,
  output logic [NUM_PINS*LBL_W-1:0] label_o
);
  localparam logic [NUM_PINS-1:0] ONE = {{(NUM_PINS-1){1'b0}}, 1'b1};

  scan_st_e            st_q;
  logic [IW-1:0]       src_q, tgt_q, pick_idx;
  logic [NUM_PINS-1:0] excl_q, base_q, cand_q, conf_q, later, unlab, wr_mask;
  logic [NUM_PINS-1:0] src_oh, tgt_oh, pick_oh;
  logic [SETTLE_W-1:0] settle_q;
  logic [LBL_W-1:0]    next_lbl_q;
  logic                rs_lo_q, in_drive, expired, pick_vld, clr, last_src;

  assign in_drive = (st_q == ST_FLO) || (st_q == ST_FHI) || (st_q == ST_RLO) || (st_q == ST_RHI);
  assign src_oh   = ONE << src_q;
  assign tgt_oh   = ONE << tgt_q;
  assign pick_oh  = ONE << pick_idx;
  assign last_src = (src_q == IW'(NUM_PINS-1));
  assign clr      = start_i && ((st_q == ST_IDLE) || (st_q == ST_DONE));
  assign wr_mask  = ((st_q == ST_COMMIT) && (conf_q != '0)) ? (conf_q | src_oh) : '0;
  assign done_o   = (st_q == ST_DONE);

  always_comb begin
    for (int j = 0; j < NUM_PINS; j++) later[j] = (j > int'(src_q));
  end

  link_settle_timer #(.SETTLE_W(SETTLE_W)) u_timer (
    .clk_i, .rst_ni,
    .restart_i (!in_drive || expired),
    .limit_i   (settle_q),
    .expired_o (expired)
  );

  link_first_set #(.N(NUM_PINS), .IW(IW)) u_pick (
    .mask_i (cand_q), .idx_o (pick_idx), .valid_o (pick_vld)
  );

  link_label_store #(.N(NUM_PINS), .LW(LBL_W)) u_lbl (
    .clk_i, .rst_ni,
    .clr_i     (clr),
    .wr_mask_i (wr_mask),
    .wr_lbl_i  (next_lbl_q),
    .labels_o  (label_o),
    .unlab_o   (unlab)
  );

  always_comb begin
    drv_en_o  = '0;
    drv_val_o = '0;
    unique case (st_q)
      ST_FLO: drv_en_o = src_oh;
      ST_FHI: begin drv_en_o = src_oh; drv_val_o = src_oh; end
      ST_RLO: drv_en_o = tgt_oh;
      ST_RHI: begin drv_en_o = tgt_oh; drv_val_o = tgt_oh; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      src_q      <= '0;
      tgt_q      <= '0;
      excl_q     <= '0;
      base_q     <= '0;
      cand_q     <= '0;
      conf_q     <= '0;
      settle_q   <= '0;
      next_lbl_q <= '0;
      rs_lo_q    <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_DONE: if (start_i) begin
          excl_q     <= excl_i;
          settle_q   <= settle_i;
          src_q      <= '0;
          next_lbl_q <= LBL_W'(1);
          st_q       <= ST_SRC;
        end
        ST_SRC: begin
          if (!excl_q[src_q] && unlab[src_q]) st_q <= ST_FLO;
          else if (last_src)                 st_q <= ST_REL;
          else                               src_q <= src_q + 1'b1;
        end
        ST_FLO: if (expired) begin
          base_q <= pin_i;
          st_q   <= ST_FHI;
        end
        ST_FHI: if (expired) begin
          cand_q <= pin_i & ~base_q & later & ~excl_q & unlab;
          conf_q <= '0;
          st_q   <= ST_RSEL;
        end
        ST_RSEL: begin
          if (!pick_vld) st_q <= ST_COMMIT;
          else begin
            tgt_q  <= pick_idx;
            cand_q <= cand_q & ~pick_oh;
            st_q   <= ST_RLO;
          end
        end
        ST_RLO: if (expired) begin
          rs_lo_q <= pin_i[src_q];
          st_q    <= ST_RHI;
        end
        ST_RHI: if (expired) begin
          if (pin_i[src_q] && !rs_lo_q) conf_q <= conf_q | tgt_oh;
          st_q <= ST_RSEL;
        end
        ST_COMMIT: begin
          if (conf_q != '0) next_lbl_q <= next_lbl_q + 1'b1;
          if (last_src) st_q <= ST_REL;
          else begin
            src_q <= src_q + 1'b1;
            st_q  <= ST_SRC;
          end
        end
        ST_REL:  st_q <= ST_DONE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assert_one_driver_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(drv_en_o));
  assert_excl_undriven_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_en_o & excl_q) == '0);
  assert_done_released_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (drv_en_o == '0));
  assert_release_before_done_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(drv_en_o) == '0));
endmodule

// File: tb/link_scan_seq_test.sv
module link_scan_seq_test;
  localparam int N  = 8;
  localparam int SW = 4;
  localparam int LW = $clog2(N/2 + 2);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [SW-1:0] settle = '0;
  logic [N-1:0]  excl = '0, rb, en, val;
  logic          done;
  logic [N*LW-1:0] labels;

  int net_id [N];
  int fol    [N];
  logic [N-1:0] stuck_hi = '0;
  int exp_lab [N];
  int checks = 0, errors = 0;
  int run = 0, step_bad = 0, drv_bad = 0, done_seen_bad = 0;
  logic [2*N-1:0] prev_ev = '0;
  logic [N-1:0]   prev_en = '0;
  logic           prev_done = 1'b0;

  always #10 clk = ~clk;

  link_scan_seq #(.NUM_PINS(N), .SETTLE_W(SW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .settle_i(settle), .excl_i(excl),
    .pin_i(rb), .drv_en_o(en), .drv_val_o(val), .done_o(done), .label_o(labels)
  );

  // board model: shared nets, one-way followers, stuck-high pins, pull-low
  always_comb begin
    for (int p = 0; p < N; p++) begin
      rb[p] = 1'b0;
      if (stuck_hi[p]) rb[p] = 1'b1;
      else begin
        for (int q = 0; q < N; q++)
          if (en[q] && net_id[q] == net_id[p]) rb[p] = rb[p] | val[q];
        if (fol[p] >= 0 && fol[p] < N)
          if (en[fol[p]]) rb[p] = rb[p] | val[fol[p]];
      end
    end
  end

  // step length and drive monitors
  always @(negedge clk) begin
    if ({en, val} == prev_ev) run++;
    else begin
      if (prev_en != '0 && run != int'(settle) + 1) step_bad++;
      run = 1;
    end
    if ($countones(en) > 1 || (en & excl) != '0) drv_bad++;
    if (done && !prev_done && (prev_en != '0 || en != '0)) done_seen_bad++;
    prev_ev   = {en, val};
    prev_en   = en;
    prev_done = done;
  end

  task automatic check(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic int lab(input int p);
    return int'(labels[p*LW +: LW]);
  endfunction

  task automatic board_clear();
    for (int p = 0; p < N; p++) begin net_id[p] = p; fol[p] = -1; end
    stuck_hi = '0;
    excl     = '0;
  endtask

  task automatic compute_exp();
    int nl;
    nl = 1;
    for (int p = 0; p < N; p++) exp_lab[p] = 0;
    for (int s = 0; s < N; s++) begin
      bit any;
      if (excl[s] || exp_lab[s] != 0) continue;
      any = 0;
      for (int j = s + 1; j < N; j++) begin
        bit same;
        if (excl[j] || exp_lab[j] != 0) continue;
        same = (net_id[j] == net_id[s]);
        if ((same || fol[j] == s) && (same || fol[s] == j)) begin
          exp_lab[j] = nl;
          any = 1;
        end
      end
      if (any) begin exp_lab[s] = nl; nl++; end
    end
  endtask

  task automatic run_scan(input string tag, input int st, input bit poke);
    int t;
    settle = SW'(st);
    compute_exp();
    step_bad = 0; drv_bad = 0; done_seen_bad = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    t = 0;
    while (!done && t < 5000) begin
      @(negedge clk); t++;
      if (poke && t == 9) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    check({tag, " R11 scan reaches done"}, int'(t < 5000), 1);
    for (int p = 0; p < N; p++) check({tag, " R6 R7 label"}, lab(p), exp_lab[p]);
    check({tag, " R10 step length"}, step_bad, 0);
    check({tag, " R3 drive rule"}, drv_bad, 0);
    check({tag, " R11 release before done"}, done_seen_bad, 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lf;
    board_clear();
    repeat (3) @(negedge clk);
    check("R1 done at reset", int'(done), 0);
    check("R1 drive at reset", int'(en), 0);
    check("R1 labels at reset", int'(labels), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_scan("no links", 0, 0);

    board_clear();
    net_id[1] = 0; net_id[5] = 2; net_id[7] = 2;   // R6 group of three incl. top pin
    run_scan("two groups", 1, 0);
    repeat (5) @(negedge clk);
    check("R2 labels hold after done", lab(7), 2);
    check("R11 done held", int'(done), 1);
    check("R11 drive released while done", int'(en), 0);

    board_clear();
    net_id[6] = 3; net_id[4] = 1;                   // R7 discovery order
    run_scan("order", 2, 0);

    board_clear();
    net_id[4] = 2; fol[6] = 2;                      // R5 one-way follower
    run_scan("follower", 0, 0);
    check("R5 follower unlinked", lab(6), 0);
    check("R4 forward group", lab(2), 1);

    board_clear();
    stuck_hi[0] = 1'b1; excl[0] = 1'b1;             // R8 excluded pins
    net_id[2] = 1; excl[5] = 1'b1; net_id[7] = 5;
    run_scan("excluded", 1, 0);
    check("R8 excluded stays 0", lab(5), 0);
    check("R8 partner of excluded", lab(7), 0);

    board_clear();
    for (int p = 0; p < N; p++) net_id[p] = 0;      // R6 R9 all one net
    run_scan("all linked R9", 3, 0);

    board_clear();
    net_id[3] = 0; net_id[6] = 2;
    run_scan("start ignored R2", 1, 1);              // start pulsed mid-scan

    @(negedge clk); start = 1'b1;                    // R2 new start clears labels
    @(negedge clk); start = 1'b0;
    check("R2 labels cleared at start", int'(labels), 0);
    while (!done) @(negedge clk);

    lf = 32'h1d3a;
    for (int it = 0; it < 24; it++) begin
      board_clear();
      for (int p = 0; p < N; p++) begin
        lf = (lf << 1) ^ (((lf >> 15) ^ (lf >> 13) ^ (lf >> 12) ^ (lf >> 10)) & 1);
        lf = lf & 32'hffff;
        if (lf[0]) net_id[p] = 10 + p;
        else net_id[p] = (lf >> 1) & 3;
        if ((lf & 32'h1c) == 32'h1c) begin
          excl[p] = 1'b1; net_id[p] = 20 + p; stuck_hi[p] = lf[5];
        end
      end
      if (it % 5 == 2) fol[7] = 1;
      run_scan("sweep", it % 4, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule